// File: doc/BRIEF.md
# Alias-Aware Instruction Cache Line Invalidate Sequencer

This block converts one invalidate request into the per-line command stream a virtually indexed, physically tagged instruction cache needs. A request carries a physical start address, a byte length and, optionally, a virtual address. The block floors the start to a line boundary, grows the length by the bytes it dropped, and counts the whole lines in the result. It then emits one or more command beats per line.

When a cache way is larger than a page, a line can sit in several sets, and a physical address alone cannot tell which one. The block handles this in two ways. Without a virtual address, it repeats the command for every possible alias. With a virtual address, it sends the exact index. A build-time choice selects the command format. In the legacy format, each beat is a single address, and alias or virtual-index information is packed into the line-offset bits. In the split format, a tag beat is followed by one or more index beats.

Requests use a valid/ready handshake. Command beats use valid/ready with backpressure. A one-cycle done pulse marks the end of each request.

Top module: `icache_alias_inv`

## Requirements
- R1: The start address is floored to a line boundary, and the dropped offset is added to the length. The line count is that sum divided by the line size, rounded up. The range end is exclusive, so no line beyond it is commanded. Line addresses step by one line size.
- R2: The alias count is the way size (cache bytes / ways) divided by the page size. A ratio of 0 or 1 gives 1 alias; a ratio of 2 gives 2; a ratio of 4 gives 4. Any other ratio drives `cfgBad` high; otherwise `cfgBad` is low. With 1 alias in the legacy format, each line produces exactly one beat equal to the line address.
- R3: Legacy format, no virtual address: each line produces one beat per alias, in ascending order k = 0..A-1. Each beat's address is the line address ORed with k. `cmdIsTag` is 0.
- R4: Legacy format with a virtual address: each line produces exactly one beat. Its address is the line address with virtual bits [PAGE_SHIFT+LINE_SHIFT-1:PAGE_SHIFT] (bits 17:13 by default) placed in bits [LINE_SHIFT-1:0]. These bits are taken from the request's virtual address and are the same for every line.
- R5: Split format, no virtual address: each line produces a tag beat (`cmdIsTag`=1) carrying the line address. Then A index beats follow (`cmdIsTag`=0). Index beat k carries the line address with its alias field, bits [PAGE_SHIFT+log2(A)-1:PAGE_SHIFT], forced to k, for k ascending from 0.
- R6: Split format with a virtual address: each line produces a tag beat with the physical line address, then one index beat. The index beat carries the line-aligned virtual address. Both addresses advance by one line size per line.
- R7: `reqReady` is high only while the block is idle. Once a request is accepted, `reqReady` stays low, and further requests have no effect on the command stream until done has pulsed.
- R8: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdAddr` and `cmdIsTag` hold their values.
- R9: `done` is high for exactly one cycle: the cycle after the last beat's handshake. For a zero length, no beats are issued and `done` is high the cycle after acceptance. `reqReady` returns high the cycle after `done`.
- R10: After reset, `reqReady` is 1, and `cmdValid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken this cycle if valid |
| reqPaddr | input | ADDR_W | Physical start address |
| reqLen | input | LEN_W | Length in bytes |
| reqHasV | input | 1 | Virtual address supplied |
| reqVaddr | input | ADDR_W | Virtual start address |
| cmdValid | output | 1 | Command beat valid |
| cmdReady | input | 1 | Downstream accepts beat |
| cmdIsTag | output | 1 | Beat is a tag beat (split format only) |
| cmdAddr | output | ADDR_W | Beat address |
| done | output | 1 | One-cycle end-of-request pulse |
| cfgBad | output | 1 | Unsupported way-to-page ratio |

## Verification
The bench drives inputs and samples outputs on falling edges. A request presented on one falling edge is taken at the next rising edge. At each later falling edge, a beat is recorded only if `cmdValid` and the bench's own `cmdReady` are both high, because that beat's handshake completes at the following rising edge.

`done` must appear on the first falling edge after the last recorded handshake. For a zero length, that is the first falling edge after acceptance. It must be gone, with `reqReady` back, one edge later. The recorded beats are compared in order against a list built from the line arithmetic alone. This comparison is repeated with stalling ready patterns and with a second request held on the bus while the block is busy.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
  localparam int BEAT_W = 3;

  typedef struct packed {
    logic              load;
    logic              nextLine;
    logic [BEAT_W-1:0] beatIdx;
  } invStrb_t;
endpackage

// File: rtl/icinv_dpath.sv
module icinv_dpath
  import icinv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_SHIFT = 5,
  parameter int PAGE_SHIFT = 13,
  parameter int ALIAS_N    = 4,
  parameter int CNT_W      = 13,
  parameter bit SPLIT      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqPaddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqHasV,
  input  invStrb_t          strb,
  output logic [CNT_W-1:0]  lineCount,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdIsTag
);
  localparam int LINE_BYTES = 1 << LINE_SHIFT;
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIAS_N - 1) << PAGE_SHIFT;

  logic [LEN_W+1:0]  sumLen;
  logic [ADDR_W-1:0] lineP, lineV;
  logic              hasVq;

  // rounded-up line count over the floored range
  assign sumLen = (LEN_W+2)'(reqLen) + (LEN_W+2)'(reqPaddr[LINE_SHIFT-1:0])
                + (LEN_W+2)'(LINE_BYTES - 1);
  assign lineCount = (reqLen == '0) ? '0 : sumLen[LEN_W+1:LINE_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineP <= '0;
      lineV <= '0;
      hasVq <= 1'b0;
    end else if (strb.load) begin
      lineP <= reqPaddr & ~LMASK;
      lineV <= reqVaddr & ~LMASK;
      hasVq <= reqHasV;
    end else if (strb.nextLine) begin
      lineP <= lineP + ADDR_W'(LINE_BYTES);
      if (SPLIT) lineV <= lineV + ADDR_W'(LINE_BYTES);
    end
  end

  generate
    if (SPLIT) begin : g_split
      logic [ADDR_W-1:0] aliasIdx;
      assign aliasIdx = (lineP & ~AMASK)
                      | (ADDR_W'(strb.beatIdx - BEAT_W'(1)) << PAGE_SHIFT);
      assign cmdIsTag = (strb.beatIdx == '0);
      assign cmdAddr  = cmdIsTag ? lineP : (hasVq ? lineV : aliasIdx);
    end else begin : g_legacy
      logic [ADDR_W-1:0] vBits;
      assign vBits    = ADDR_W'(lineV[PAGE_SHIFT +: LINE_SHIFT]);
      assign cmdIsTag = 1'b0;
      assign cmdAddr  = hasVq ? (lineP | vBits) : (lineP | ADDR_W'(strb.beatIdx));
    end
  endgenerate

  AST_LINE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (lineP[LINE_SHIFT-1:0] == '0)); // R1
endmodule

// File: rtl/icinv_ctrl.sv
module icinv_ctrl
  import icinv_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int ALIAS_N = 4,
  parameter bit SPLIT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqHasV,
  input  logic [CNT_W-1:0] lineCount,
  input  logic             cmdReady,
  output logic             reqReady,
  output logic             cmdValid,
  output logic             done,
  output invStrb_t         strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} seqState_t;

  seqState_t         state;
  logic [CNT_W-1:0]  linesLeft;
  logic [BEAT_W-1:0] beatIdx, lastBeat;
  logic              hasV, beatLast;

  generate
    if (SPLIT) begin : g_split
      assign lastBeat = hasV ? BEAT_W'(1) : BEAT_W'(ALIAS_N);
    end else begin : g_legacy
      assign lastBeat = hasV ? BEAT_W'(0) : BEAT_W'(ALIAS_N - 1);
    end
  endgenerate

  assign reqReady      = (state == ST_IDLE);
  assign cmdValid      = (state == ST_BUSY);
  assign done          = (state == ST_FIN);
  assign beatLast      = (beatIdx == lastBeat);
  assign strb.load     = reqReady && reqValid;
  assign strb.nextLine = cmdValid && cmdReady && beatLast;
  assign strb.beatIdx  = beatIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      linesLeft <= '0;
      beatIdx   <= '0;
      hasV      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          hasV      <= reqHasV;
          linesLeft <= lineCount;
          beatIdx   <= '0;
          state     <= (lineCount == '0) ? ST_FIN : ST_BUSY;
        end
        ST_BUSY: if (cmdReady) begin
          if (beatLast) begin
            beatIdx <= '0;
            if (linesLeft == CNT_W'(1)) state <= ST_FIN;
            else linesLeft <= linesLeft - CNT_W'(1);
          end else begin
            beatIdx <= beatIdx + BEAT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && reqReady); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load && (lineCount == '0) |=> done && !cmdValid); // R9
endmodule

// File: rtl/icache_alias_inv.sv
module icache_alias_inv
  import icinv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int LINE_SHIFT  = 5,
  parameter int PAGE_SHIFT  = 13,
  parameter int CACHE_BYTES = 65536,
  parameter int WAYS        = 2,
  parameter bit SPLIT       = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqPaddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqHasV,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic              cmdIsTag,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              done,
  output logic              cfgBad
);
  localparam int WAY_BYTES = CACHE_BYTES / WAYS;
  localparam int RATIO     = WAY_BYTES >> PAGE_SHIFT;
  localparam int ALIAS_N   = (RATIO == 4) ? 4 : ((RATIO == 2) ? 2 : 1);
  localparam bit CFG_BAD   = !((RATIO <= 2) || (RATIO == 4));
  localparam int CNT_W     = LEN_W + 2 - LINE_SHIFT;

  invStrb_t         strb;
  logic [CNT_W-1:0] lineCount;

  assign cfgBad = CFG_BAD;

  icinv_ctrl #(.CNT_W(CNT_W), .ALIAS_N(ALIAS_N), .SPLIT(SPLIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqHasV(reqHasV),
    .lineCount(lineCount), .cmdReady(cmdReady), .reqReady(reqReady),
    .cmdValid(cmdValid), .done(done), .strb(strb)
  );

  icinv_dpath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SHIFT(LINE_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT), .ALIAS_N(ALIAS_N), .CNT_W(CNT_W), .SPLIT(SPLIT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .reqPaddr(reqPaddr), .reqLen(reqLen),
    .reqVaddr(reqVaddr), .reqHasV(reqHasV), .strb(strb),
    .lineCount(lineCount), .cmdAddr(cmdAddr), .cmdIsTag(cmdIsTag)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdIsTag)); // R8
  AST_TAG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdIsTag |-> (cmdAddr[LINE_SHIFT-1:0] == '0)); // R5
endmodule

// File: tb/icache_alias_inv_tb.sv
`timescale 1ns/1ps
module icache_alias_inv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  rv = '0;
  logic [3:0]  rdy, cv, tg, dn, bad;
  logic [31:0] ca [4];
  logic [31:0] paddr = '0, vaddr = '0;
  logic [15:0] len = '0;
  logic        hasV = 1'b0;
  logic        cmdReady = 1'b1;

  int nChecks = 0;
  int nFails  = 0;

  icache_alias_inv u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(rv[0]), .reqReady(rdy[0]),
    .reqPaddr(paddr), .reqLen(len), .reqHasV(hasV), .reqVaddr(vaddr),
    .cmdValid(cv[0]), .cmdReady(cmdReady), .cmdIsTag(tg[0]), .cmdAddr(ca[0]),
    .done(dn[0]), .cfgBad(bad[0]));

  icache_alias_inv #(.CACHE_BYTES(32768), .SPLIT(1'b1)) u_split (
    .clk(clk), .rst_n(rst_n), .reqValid(rv[1]), .reqReady(rdy[1]),
    .reqPaddr(paddr), .reqLen(len), .reqHasV(hasV), .reqVaddr(vaddr),
    .cmdValid(cv[1]), .cmdReady(cmdReady), .cmdIsTag(tg[1]), .cmdAddr(ca[1]),
    .done(dn[1]), .cfgBad(bad[1]));

  icache_alias_inv #(.CACHE_BYTES(16384)) u_flat (
    .clk(clk), .rst_n(rst_n), .reqValid(rv[2]), .reqReady(rdy[2]),
    .reqPaddr(paddr), .reqLen(len), .reqHasV(hasV), .reqVaddr(vaddr),
    .cmdValid(cv[2]), .cmdReady(cmdReady), .cmdIsTag(tg[2]), .cmdAddr(ca[2]),
    .done(dn[2]), .cfgBad(bad[2]));

  icache_alias_inv #(.CACHE_BYTES(49152)) u_bad (
    .clk(clk), .rst_n(rst_n), .reqValid(rv[3]), .reqReady(rdy[3]),
    .reqPaddr(paddr), .reqLen(len), .reqHasV(hasV), .reqVaddr(vaddr),
    .cmdValid(cv[3]), .cmdReady(cmdReady), .cmdIsTag(tg[3]), .cmdAddr(ca[3]),
    .done(dn[3]), .cfgBad(bad[3]));

  // stimulus table: dut, paddr, len, hasV, vaddr, stall, pester
  localparam int NV = 8;
  localparam int          T_DUT   [NV] = '{0, 0, 0, 1, 1, 2, 0, 1};
  localparam logic [31:0] T_PADDR [NV] = '{32'h0001_2345, 32'h0000_1000, 32'h0000_2010,
                                           32'h0000_4104, 32'h0000_8020, 32'h0000_0300,
                                           32'h0000_1234, 32'h0000_5678};
  localparam logic [15:0] T_LEN   [NV] = '{16'h40, 16'h20, 16'h30, 16'h40, 16'h41,
                                           16'h21, 16'h0, 16'h0};
  localparam logic        T_HASV  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] T_VADDR [NV] = '{32'h0, 32'h0, 32'h0003_6000, 32'h0,
                                           32'h7FF3_A031, 32'h0, 32'h0, 32'h1234_5678};
  localparam logic        T_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        T_PEST  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  task automatic check(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic runVec(input int d, input logic [31:0] pa, input logic [15:0] ln,
                        input logic hv, input logic [31:0] va,
                        input logic stall, input logic pester);
    logic [31:0] capA [64];
    logic        capT [64];
    int          nCap = 0;
    bit          lastHs = 1'b0;
    bit          first = 1'b1;
    bit          finished = 1'b0;
    int          aliasN, lines, e;
    bit          split;
    string       tag;
    logic [31:0] p, v, expA;
    logic        expT;

    @(negedge clk);
    paddr = pa; len = ln; hasV = hv; vaddr = va; cmdReady = 1'b1;
    rv[d] = 1'b1;
    @(negedge clk);
    if (pester) begin
      paddr = 32'hDEAD_BEE0; len = 16'h5; vaddr = 32'h0;
    end else begin
      rv[d] = 1'b0;
    end
    for (int it = 0; it < 400; it++) begin
      cmdReady = stall ? ((it % 3) != 1) : 1'b1;
      if (dn[d]) begin
        check((ln == 0) ? first : lastHs,
              $sformatf("R9 done timing dut %0d actual first=%0d lastHs=%0d expected 1", d, first, lastHs));
        finished = 1'b1;
        rv[d] = 1'b0;
        break;
      end
      if (!first || ln != 0)
        check(rdy[d] == 1'b0, $sformatf("R7 ready while busy dut %0d actual %0b expected 0", d, rdy[d]));
      lastHs = 1'b0;
      if (cv[d] && cmdReady) begin
        if (nCap < 64) begin
          capA[nCap] = ca[d];
          capT[nCap] = tg[d];
        end
        nCap++;
        lastHs = 1'b1;
      end
      first = 1'b0;
      @(negedge clk);
    end
    rv[d] = 1'b0;
    cmdReady = 1'b1;
    check(finished, $sformatf("R9 done never seen dut %0d actual 0 expected 1", d));
    @(negedge clk);
    check(dn[d] == 1'b0 && rdy[d] == 1'b1,
          $sformatf("R9 done pulse/ready dut %0d actual dn=%0b rdy=%0b expected dn=0 rdy=1", d, dn[d], rdy[d]));

    // expected stream from line arithmetic
    aliasN = (d == 0) ? 4 : ((d == 1) ? 2 : 1);
    split  = (d == 1);
    tag    = split ? (hv ? "R6" : "R5") : (hv ? "R4" : ((d == 2) ? "R2" : "R3"));
    lines  = (ln == 0) ? 0 : int'(((pa & 32'h1F) + 32'(ln) + 32'd31) >> 5);
    e = 0;
    for (int j = 0; j < lines; j++) begin
      p = (pa & ~32'h1F) + 32'(32 * j);
      v = (va & ~32'h1F) + 32'(32 * j);
      if (!split) begin
        if (hv) begin
          expA = p | ((va >> 13) & 32'h1F); expT = 1'b0;
          if (e < nCap && e < 64)
            check(capA[e] == expA && capT[e] == expT,
                  $sformatf("%s beat %0d actual %h expected %h", tag, e, capA[e], expA));
          e++;
        end else begin
          for (int k = 0; k < aliasN; k++) begin
            expA = p | 32'(k);
            if (e < nCap && e < 64)
              check(capA[e] == expA && capT[e] == 1'b0,
                    $sformatf("%s beat %0d actual %h expected %h", tag, e, capA[e], expA));
            e++;
          end
        end
      end else begin
        if (e < nCap && e < 64)
          check(capA[e] == p && capT[e] == 1'b1,
                $sformatf("%s tag beat %0d actual %h/%0b expected %h/1", tag, e, capA[e], capT[e], p));
        e++;
        if (hv) begin
          if (e < nCap && e < 64)
            check(capA[e] == v && capT[e] == 1'b0,
                  $sformatf("%s index beat %0d actual %h expected %h", tag, e, capA[e], v));
          e++;
        end else begin
          for (int k = 0; k < aliasN; k++) begin
            expA = (p & ~(32'(aliasN - 1) << 13)) | (32'(k) << 13);
            if (e < nCap && e < 64)
              check(capA[e] == expA && capT[e] == 1'b0,
                    $sformatf("%s index beat %0d actual %h expected %h", tag, e, capA[e], expA));
            e++;
          end
        end
      end
    end
    check(nCap == e, $sformatf("R1 beat count dut %0d actual %0d expected %0d", d, nCap, e));
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rdy == 4'hF && cv == 4'h0 && dn == 4'h0,
          $sformatf("R10 in reset actual rdy=%b cv=%b dn=%b expected 1111/0000/0000", rdy, cv, dn));
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy == 4'hF && cv == 4'h0 && dn == 4'h0,
          $sformatf("R10 after reset actual rdy=%b cv=%b dn=%b expected 1111/0000/0000", rdy, cv, dn));
    // R2 geometry flag
    check(bad == 4'b1000, $sformatf("R2 cfgBad actual %b expected 1000", bad));

    for (int i = 0; i < NV; i++)
      runVec(T_DUT[i], T_PADDR[i], T_LEN[i], T_HASV[i], T_VADDR[i], T_STALL[i], T_PEST[i]);

    // directed corners: exact-line end (R1), page-crossing alias split (R5), stalled legacy vaddr (R4, R8)
    runVec(0, 32'h0000_1FE0, 16'h0020, 1'b0, 32'h0, 1'b1, 1'b0);
    runVec(1, 32'h0000_3FF0, 16'h0020, 1'b0, 32'h0, 1'b1, 1'b1);
    runVec(0, 32'h0000_0004, 16'h003C, 1'b1, 32'h0002_E000, 1'b1, 1'b0);
    runVec(2, 32'h0000_0010, 16'h0001, 1'b1, 32'h0001_2000, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule